// File: doc/BRIEF.md
# Write Delay Eye Centering Engine

This block trains the write-data delay of one byte lane. A start pulse launches a sweep across every tap of the lane's delay line, from tap 0 upward. At each tap it runs one trial: it writes a fixed 32-bit training word through a simple memory-side port, reads the word back, and compares it with what was sent. Each trial either passes or fails.

The passing taps mark the two edges of the write-data eye. The engine keeps the first and the last passing tap and requires the passing taps to form a single unbroken run. After the last tap it publishes the centre of that run as the final delay code, together with a done flag and a fail flag. The centre is the best place because the delay of each element drifts with process and temperature, and the centre leaves the most margin on both sides.

A behavioural model of the delay line and the memory sits behind the memory-side port. It returns the word intact at good taps and damaged at bad ones, and it returns read data one or more cycles after the read request.

Top module: `wr_eye_center`

## Requirements
- R1: After reset, `done`, `fail`, `dly_code`, `mem_wr` and `mem_rd` are all 0.
- R2: A `start` sampled high while the engine is idle begins a sweep. At that same clock edge `done`, `fail` and `dly_code` clear to 0.
- R3: Each trial asserts `mem_wr` for exactly one cycle with `mem_tap` equal to the trial tap. `mem_rd` follows in the next cycle, and the engine then waits for `mem_rvld`. The trials cover taps 0 to 127 in ascending order, one trial per tap, so there are 128 writes per sweep.
- R4: `mem_wdata` is the training word 32'h5AC30F96, which is bytes 8'h5A, 8'hC3, 8'h0F, 8'h96 from bit 31 down to bit 0. A trial passes only when `mem_rdata` equals this word in all 32 bits while `mem_rvld` is high.
- R5: When the passing taps form one contiguous run from L to H, the sweep ends with `fail` = 0 and `dly_code` = (L + H) >> 1, rounded down.
- R6: When no tap passes, the sweep ends with `fail` = 1 and `dly_code` = 0.
- R7: When a passing tap follows a failing tap that itself came after an earlier pass, so that there are two or more passing runs, the sweep ends with `fail` = 1 and `dly_code` = 0.
- R8: If read data comes back N cycles after the cycle in which `mem_rd` is high, then `done` rises 128*(2+N)+1 clock cycles after the edge that accepted `start`. `fail` and `dly_code` are valid in the same cycle as that rise.
- R9: A `start` pulse during a sweep is ignored. The sweep finishes in the same cycle and with the same result as it would without the pulse.
- R10: Once `done` is high, `done`, `fail` and `dly_code` keep their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a training sweep |
| mem_tap | output | 7 | Delay tap applied in the current trial |
| mem_wr | output | 1 | One-cycle write of the training word |
| mem_rd | output | 1 | One-cycle read-back request |
| mem_wdata | output | 32 | Training word to write |
| mem_rvld | input | 1 | Read-back data valid |
| mem_rdata | input | 32 | Read-back data |
| done | output | 1 | Sweep finished, results valid |
| fail | output | 1 | No usable eye found |
| dly_code | output | 7 | Chosen write-delay tap |

## Verification
The result is due at a known cycle. It arrives 128*(2+N)+1 cycles after the edge that accepted `start`, where N is the read latency of the model. The bench counts cycles from that edge and samples between edges, so it checks the exact cycle in which `done` rises, and it checks this for both a one-cycle and a three-cycle read latency. The clearing of the outputs is checked in the first sample after the accepting edge. The write-then-read pairing of each trial is checked at every sample. The hold behaviour is checked over several cycles after `done`.

// File: rtl/eye_pkg.sv
package eye_pkg;

    // Training word, most significant byte first
    localparam logic [7:0] TRAIN_B3 = 8'h5A;
    localparam logic [7:0] TRAIN_B2 = 8'hC3;
    localparam logic [7:0] TRAIN_B1 = 8'h0F;
    localparam logic [7:0] TRAIN_B0 = 8'h96;
    localparam int unsigned TRAIN_BYTES = 4;
    localparam int unsigned TRAIN_W = 8 * TRAIN_BYTES;
    localparam logic [TRAIN_W-1:0] TRAIN_WORD = {TRAIN_B3, TRAIN_B2, TRAIN_B1, TRAIN_B0};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_RD,
        ST_WAIT,
        ST_FIN
    } eye_state_e;

    typedef struct packed {
        logic valid;
        logic pass;
    } verdict_t;

    // Floor of the mean of two taps, computed with one extra carry bit
    function automatic logic [15:0] tap_mean(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[16:1];
    endfunction

endpackage

// File: rtl/eye_seq.sv
module eye_seq
    import eye_pkg::*;
#(
    parameter int unsigned TAP_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             rvld,
    output logic [TAP_W-1:0] tap,
    output logic             wr,
    output logic             rd,
    output logic             clr,
    output logic             sample,
    output logic             fin,
    output logic             busy
);
    localparam logic [TAP_W-1:0] LAST_TAP = {TAP_W{1'b1}};

    eye_state_e st;

    assign wr     = (st == ST_WR);
    assign rd     = (st == ST_RD);
    assign busy   = (st != ST_IDLE);
    assign clr    = (st == ST_IDLE) && start;
    assign sample = (st == ST_WAIT) && rvld;
    assign fin    = (st == ST_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            tap <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    st  <= ST_WR;
                    tap <= '0;
                end
                ST_WR:   st <= ST_RD;
                ST_RD:   st <= ST_WAIT;
                ST_WAIT: if (rvld) begin
                    if (tap == LAST_TAP) begin
                        st <= ST_FIN;
                    end else begin
                        tap <= tap + 1'b1;
                        st  <= ST_WR;
                    end
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R3: a read request always follows a write one cycle later
    assert_wr_then_rd_R3: assert property (@(posedge clk) disable iff (rst)
        wr |=> rd);

    // R3: taps advance by exactly one between trials
    assert_tap_step_R3: assert property (@(posedge clk) disable iff (rst)
        (sample && tap != LAST_TAP) |=> (tap == TAP_W'($past(tap) + 1'b1)));

    // R3: write and read never overlap
    assert_wr_rd_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(wr && rd));

endmodule

// File: rtl/eye_cmp.sv
module eye_cmp
    import eye_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         sample,
    input  logic [W-1:0] got,
    input  logic [W-1:0] want,
    output verdict_t     verdict
);
    logic [W-1:0] diff;

    assign diff          = got ^ want;
    assign verdict.valid = sample;
    assign verdict.pass  = sample && (diff == '0);

endmodule

// File: rtl/eye_edge.sv
module eye_edge
    import eye_pkg::*;
#(
    parameter int unsigned TAP_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  verdict_t         verdict,
    input  logic [TAP_W-1:0] tap,
    output logic [TAP_W-1:0] center,
    output logic             bad
);
    logic             found;
    logic             closed;
    logic             split;
    logic [TAP_W-1:0] left_e;
    logic [TAP_W-1:0] right_e;
    logic [15:0]      mean16;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            found   <= 1'b0;
            closed  <= 1'b0;
            split   <= 1'b0;
            left_e  <= '0;
            right_e <= '0;
        end else if (verdict.valid) begin
            if (verdict.pass) begin
                if (!found) begin
                    found   <= 1'b1;
                    left_e  <= tap;
                    right_e <= tap;
                end else if (closed) begin
                    split <= 1'b1;
                end else begin
                    right_e <= tap;
                end
            end else if (found) begin
                closed <= 1'b1;
            end
        end
    end

    assign mean16 = tap_mean(16'(left_e), 16'(right_e));
    assign center = mean16[TAP_W-1:0];
    assign bad    = !found || split;

    // R5: right edge never lies below left edge
    assert_edge_order_R5: assert property (@(posedge clk) disable iff (rst)
        found |-> (right_e >= left_e));

    // R7: a second run can only be flagged after a first one closed
    assert_split_after_close_R7: assert property (@(posedge clk) disable iff (rst)
        split |-> (found && closed));

endmodule

// File: rtl/wr_eye_center.sv
module wr_eye_center
    import eye_pkg::*;
#(
    parameter int unsigned TAP_W = 7,
    parameter logic [TRAIN_W-1:0] PATTERN = TRAIN_WORD
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic [TAP_W-1:0]   mem_tap,
    output logic               mem_wr,
    output logic               mem_rd,
    output logic [TRAIN_W-1:0] mem_wdata,
    input  logic               mem_rvld,
    input  logic [TRAIN_W-1:0] mem_rdata,
    output logic               done,
    output logic               fail,
    output logic [TAP_W-1:0]   dly_code
);
    logic             clr;
    logic             sample;
    logic             fin;
    logic             busy;
    logic [TAP_W-1:0] center;
    logic             bad;
    verdict_t         verdict;

    eye_seq #(.TAP_W(TAP_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .rvld   (mem_rvld),
        .tap    (mem_tap),
        .wr     (mem_wr),
        .rd     (mem_rd),
        .clr    (clr),
        .sample (sample),
        .fin    (fin),
        .busy   (busy)
    );

    eye_cmp #(.W(TRAIN_W)) u_cmp (
        .sample  (sample),
        .got     (mem_rdata),
        .want    (PATTERN),
        .verdict (verdict)
    );

    eye_edge #(.TAP_W(TAP_W)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .verdict (verdict),
        .tap     (mem_tap),
        .center  (center),
        .bad     (bad)
    );

    assign mem_wdata = PATTERN;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            done     <= 1'b0;
            fail     <= 1'b0;
            dly_code <= '0;
        end else if (fin) begin
            done     <= 1'b1;
            fail     <= bad;
            dly_code <= bad ? '0 : center;
        end
    end

    // R6, R7: a failed sweep always reports tap zero
    assert_fail_code_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (done && fail) |-> (dly_code == '0));

    // R10: results hold while no new start arrives
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(dly_code) && $stable(fail)));

    // R8: done is never raised while a sweep is in progress
    assert_no_done_busy_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    // R2: an accepted start clears done on the next cycle
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        clr |=> !done);

endmodule

// File: tb/tb_wr_eye_center.sv
module tb_wr_eye_center;
    localparam int NT = 128;
    localparam logic [31:0] TRAIN = 32'h5AC30F96;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [6:0]  mem_tap;
    logic        mem_wr;
    logic        mem_rd;
    logic [31:0] mem_wdata;
    logic        mem_rvld;
    logic [31:0] mem_rdata;
    logic        done;
    logic        fail;
    logic [6:0]  dly_code;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [NT-1:0] pass_map;
    int lat = 1;
    int exp_tap;
    bit r3_bad;
    bit r4_bad;
    int rd_cnt = 0;
    bit last_wr = 0;
    logic [31:0] stored;

    always #4 clk = ~clk;

    wr_eye_center dut (
        .clk(clk), .rst(rst), .start(start), .mem_tap(mem_tap),
        .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_wdata(mem_wdata),
        .mem_rvld(mem_rvld), .mem_rdata(mem_rdata),
        .done(done), .fail(fail), .dly_code(dly_code)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural delay line plus memory
    initial begin
        mem_rvld  = 1'b0;
        mem_rdata = '0;
        stored    = '0;
        forever begin
            @(negedge clk);
            mem_rvld = 1'b0;
            if (rd_cnt > 0) begin
                rd_cnt--;
                if (rd_cnt == 0) begin
                    mem_rvld  = 1'b1;
                    mem_rdata = stored;
                end
            end
            if (mem_rd) begin
                if (!last_wr) r3_bad = 1;
                rd_cnt = lat;
            end
            if (mem_wr) begin
                if (int'(mem_tap) != exp_tap) r3_bad = 1;
                if (mem_wdata != TRAIN) r4_bad = 1;
                if (pass_map[mem_tap]) stored = mem_wdata;
                else stored = mem_wdata ^ (32'h1 << (mem_tap % 32));
                exp_tap++;
            end
            last_wr = mem_wr;
        end
    end

    task automatic set_window(input int lo, input int hi);
        pass_map = '0;
        for (int i = lo; i <= hi; i++) pass_map[i] = 1'b1;
    endtask

    // Runs one sweep and checks it against values derived from pass_map
    task automatic run_sweep(input string req, input bit poke);
        int first = -1;
        int last = -1;
        int runs = 0;
        bit exp_fail;
        int exp_code;
        int cnt = 0;
        int due;
        for (int i = 0; i < NT; i++) begin
            if (pass_map[i] && (i == 0 || !pass_map[i-1])) runs++;
            if (pass_map[i]) begin
                if (first < 0) first = i;
                last = i;
            end
        end
        exp_fail = (runs != 1);
        exp_code = exp_fail ? 0 : (first + last) / 2;
        due = NT * (2 + lat) + 1;
        exp_tap = 0;
        r3_bad = 0;
        r4_bad = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done && !fail && dly_code == 0, "R2", "clear on start",
            int'(dly_code) + 1000 * int'(done), 0);
        while (!done && cnt < 5000) begin
            @(negedge clk);
            cnt++;
            if (poke && cnt == 100) start = 1'b1;
            if (poke && cnt == 101) start = 1'b0;
        end
        chk(cnt == due, poke ? "R9" : "R8", "done cycle", cnt, due);
        chk(fail == exp_fail, req, "fail flag", int'(fail), int'(exp_fail));
        chk(int'(dly_code) == exp_code, req, "delay code", int'(dly_code), exp_code);
        chk(!r3_bad && exp_tap == NT, "R3", "trial order", exp_tap, NT);
        chk(!r4_bad, "R4", "training word", int'(r4_bad), 0);
        repeat (4) @(negedge clk);
        chk(done && int'(dly_code) == exp_code && fail == exp_fail, "R10", "hold",
            int'(dly_code), exp_code);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        start = 1'b0;
        pass_map = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!done && !fail && dly_code == 0 && !mem_wr && !mem_rd, "R1", "reset state",
            int'(done) + int'(fail) + int'(dly_code), 0);

        set_window(40, 80);   run_sweep("R5", 0);
        set_window(0, 0);     run_sweep("R5", 0);
        set_window(127, 127); run_sweep("R5", 0);
        set_window(0, 127);   run_sweep("R5", 0);
        set_window(10, 11);   run_sweep("R5", 0);
        pass_map = '0;        run_sweep("R6", 0);
        set_window(5, 10); pass_map[30:20] = '1; run_sweep("R7", 0);
        set_window(60, 60); pass_map[62] = 1'b1; run_sweep("R7", 0);
        set_window(3, 100);   run_sweep("R9", 1);
        for (int lo = 0; lo < NT; lo += 21)
            for (int hi = lo; hi < NT; hi += 37) begin
                set_window(lo, hi);
                run_sweep("R5", 0);
            end
        // R4: a single flipped bit in the read-back fails the tap
        lat = 3;
        set_window(17, 90);   run_sweep("R4", 0);
        lat = 1;

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule